// File: doc/BRIEF.md
# ECC Error Capture and Status Logger

This block sits beside a DRAM controller's ECC datapath and keeps a record of memory errors. The datapath pulses a strobe for a correctable (single-bit) event or an uncorrectable (multi-bit) event. With each strobe it presents the failing cache-line address, the channel, the 8-bit ECC syndrome and an 8-bit destination code. Three further strobes report a refresh timeout, a lock error outside DRAM and a thermal event. Each event sets a sticky bit in a 16-bit status register. The address, channel, syndrome and destination of the logged ECC error are held in capture registers.

Software reaches the registers through a small word-indexed port. Reads are combinational. Writes take effect at the clock edge. Status bits clear when a 1 is written to them. The capture of an uncorrectable error takes priority: it replaces the data of a logged correctable error. Later events leave the captured data alone until software clears the matching status bits.

There are three reporting paths: a system-error path, a management-interrupt path and a configuration-interrupt path. Each has its own enable register and its own output. An output gives a one-cycle pulse when a status bit rises while that bit is enabled for the path.

Top module: `ecc_err_logger`

## Requirements
- R1: After reset, every register reads zero and all three pulse outputs are low.
- R2: Status bit 0 is set by `ce_evt`, bit 1 by `ue_evt`, bit 8 by `rfsh_evt`, bit 9 by `lock_evt` and bit 11 by `therm_evt`. Set bits stay set until cleared. All other status bits read 0.
- R3: Writing the status register (index 0) clears every defined bit whose write-data bit is 1 and leaves bits written with 0 unchanged. An event arriving in the same cycle as a clear of its bit keeps the bit set.
- R4: The address register (index 1) reads {line[24:0], 6'b0, chan}, where line is `err_line` (physical address bits 32:7) of the logged error. The extension register (index 2) reads line[25] in bit 0 and zeros above it.
- R5: The syndrome register (index 3) reads the captured syndrome in bits 7:0 and the captured destination code in bits 15:8.
- R6: An event is captured when no error of its kind or of higher priority is logged. A correctable event is captured only while status bits 1:0 are both 0. An uncorrectable event is captured whenever status bit 1 is 0.
- R7: An uncorrectable event that arrives while a correctable error is logged overwrites the captured address, channel, syndrome and destination.
- R8: A correctable event while bit 0 or bit 1 is set leaves the captured data unchanged. An uncorrectable event while bit 1 is set also leaves it unchanged.
- R9: Correctable and uncorrectable strobes in the same cycle set both bits and capture the data for the uncorrectable error.
- R10: A path's pulse output is high for the one cycle after the edge at which a status bit goes from 0 to 1 while that bit is set in the path's enable register (system error: index 4; management interrupt: index 5; configuration interrupt: index 6). An already-set bit produces no pulse.
- R11: The system-error enable implements bits 11, 9, 8, 1 and 0, matching the status layout. The other two enables implement only bits 1:0. Unimplemented bits read 0.
- R12: Writes to indices 1, 2 and 3 are ignored. Index 7 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_evt | input | 1 | Correctable ECC event strobe |
| ue_evt | input | 1 | Uncorrectable ECC event strobe |
| rfsh_evt | input | 1 | Refresh timeout strobe |
| lock_evt | input | 1 | Lock error (outside DRAM) strobe |
| therm_evt | input | 1 | Thermal event strobe |
| err_line | input | 26 | Failing physical address bits 32:7 |
| err_chan | input | 1 | Failing channel |
| err_syn | input | 8 | ECC syndrome |
| err_dest | input | 8 | Destination code of the failing access |
| reg_addr | input | 3 | Register word index |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| serr_pulse | output | 1 | System-error path pulse |
| smi_pulse | output | 1 | Management-interrupt path pulse |
| sci_pulse | output | 1 | Configuration-interrupt path pulse |

## Verification
The bench checks the capture priority in four cases. An uncorrectable error replacing a logged correctable one catches a design that freezes on the first error. A correctable error arriving after either kind is logged catches one that overwrites freely. Simultaneous strobes catch one that picks the correctable data. It also checks that the low address bits and bit 32 land in the right registers.

A clear written in the same cycle as a new event must not lose that event. A design that gives the clear priority would drop the error silently. Pulses are checked for a single cycle, for the correct path only and for no pulse when the bit is already set. A level output or a missing rise detector would fail these checks. Enable masking and read-only capture registers are checked by writing all ones.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  localparam int STAT_W  = 16;
  localparam int WD_W    = 16;
  localparam int RD_W    = 32;
  localparam int PA_W    = 33;
  localparam int LINE_LSB = 7;
  localparam int LINE_W  = PA_W - LINE_LSB;
  localparam int SYN_W   = 8;
  localparam int DST_W   = 8;
  localparam int RA_W    = 3;
  localparam int NPATH   = 3;

  localparam int BIT_CE    = 0;
  localparam int BIT_UE    = 1;
  localparam int BIT_RFSH  = 8;
  localparam int BIT_LOCK  = 9;
  localparam int BIT_THERM = 11;

  localparam logic [STAT_W-1:0] STAT_MASK   = 16'h0B03;
  localparam logic [STAT_W-1:0] NARROW_MASK = 16'h0003;

  typedef enum logic [RA_W-1:0] {
    RA_STAT    = 3'd0,
    RA_ADDR    = 3'd1,
    RA_EXT     = 3'd2,
    RA_SYND    = 3'd3,
    RA_EN_SERR = 3'd4,
    RA_EN_SMI  = 3'd5,
    RA_EN_SCI  = 3'd6
  } reg_sel_e;
endpackage

// File: rtl/ecc_status_reg.sv
module ecc_status_reg
  import ecc_log_pkg::*;
#(
  parameter int W = STAT_W,
  parameter logic [W-1:0] MASK = STAT_MASK
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_bits,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] stat_q,
  output logic [W-1:0] rise
);
  logic [W-1:0] stat_d;
  logic         stat_en;

  always_comb begin
    stat_d  = ((stat_q & ~clr_bits) | set_bits) & MASK;
    stat_en = |(set_bits | clr_bits);
    rise    = stat_d & ~stat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_en) stat_q <= stat_d;
  end

  // R2: a set bit only drops when a clear was written for it
  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(stat_q) & ~$past(clr_bits)) & ~stat_q) == '0));

  // R2: a correctable strobe always leaves bit 0 set
  p_ce_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_bits[BIT_CE] |=> stat_q[BIT_CE]);

  // R3: an event beats a same-cycle clear
  p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (set_bits[BIT_UE] && clr_bits[BIT_UE]) |=> stat_q[BIT_UE]);
endmodule

// File: rtl/ecc_capture.sv
module ecc_capture
  import ecc_log_pkg::*;
#(
  parameter int LW = LINE_W,
  parameter int SW = SYN_W,
  parameter int DW = DST_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_evt,
  input  logic          ue_evt,
  input  logic          logged_ce,
  input  logic          logged_ue,
  input  logic [LW-1:0] line_in,
  input  logic          chan_in,
  input  logic [SW-1:0] syn_in,
  input  logic [DW-1:0] dest_in,
  output logic [LW-1:0] line_q,
  output logic          chan_q,
  output logic [SW-1:0] syn_q,
  output logic [DW-1:0] dest_q
);
  logic          cap_ue, cap_ce, cap_en;
  logic [LW-1:0] line_d;
  logic          chan_d;
  logic [SW-1:0] syn_d;
  logic [DW-1:0] dest_d;

  always_comb begin
    cap_ue = ue_evt && !logged_ue;
    cap_ce = ce_evt && !ue_evt && !logged_ue && !logged_ce;
    cap_en = cap_ue || cap_ce;
    line_d = line_in;
    chan_d = chan_in;
    syn_d  = syn_in;
    dest_d = dest_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      chan_q <= 1'b0;
      syn_q  <= '0;
      dest_q <= '0;
    end else if (cap_en) begin
      line_q <= line_d;
      chan_q <= chan_d;
      syn_q  <= syn_d;
      dest_q <= dest_d;
    end
  end

  // R7: an uncorrectable event not yet logged takes over the capture
  p_ue_over_ce_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ue_evt && !logged_ue) |=> (syn_q == $past(syn_in) && line_q == $past(line_in)));

  // R8: a correctable event never disturbs an existing log
  p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_evt && !ue_evt && (logged_ce || logged_ue)) |=> ($stable(syn_q) && $stable(line_q)
      && $stable(chan_q) && $stable(dest_q)));
endmodule

// File: rtl/ecc_report_path.sv
module ecc_report_path
  import ecc_log_pkg::*;
#(
  parameter int W = STAT_W,
  parameter logic [W-1:0] MASK = NARROW_MASK
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_wr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] rise,
  output logic [W-1:0] en_q,
  output logic         pulse_q
);
  logic [W-1:0] en_d;
  logic         pulse_d;

  always_comb begin
    en_d    = wdata & MASK;
    pulse_d = |(rise & en_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_wr) en_q <= en_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_d;
  end

  // R11: unimplemented enable bits never become set
  p_en_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_q & ~MASK) == '0));

  // R10: a pulse requires some enable bit in the previous cycle
  p_pulse_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> $past(en_q != '0));
endmodule

// File: rtl/ecc_err_logger.sv
module ecc_err_logger
  import ecc_log_pkg::*;
#(
  parameter int LW = LINE_W,
  parameter int SW = SYN_W,
  parameter int DW = DST_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ce_evt,
  input  logic            ue_evt,
  input  logic            rfsh_evt,
  input  logic            lock_evt,
  input  logic            therm_evt,
  input  logic [LW-1:0]   err_line,
  input  logic            err_chan,
  input  logic [SW-1:0]   err_syn,
  input  logic [DW-1:0]   err_dest,
  input  logic [RA_W-1:0] reg_addr,
  input  logic            reg_wr,
  input  logic [WD_W-1:0] reg_wdata,
  output logic [RD_W-1:0] reg_rdata,
  output logic            serr_pulse,
  output logic            smi_pulse,
  output logic            sci_pulse
);
  localparam int RSVD_W = LINE_LSB - 1;

  reg_sel_e          sel;
  logic [STAT_W-1:0] set_bits, clr_bits, stat_q, rise;
  logic [LW-1:0]     line_q;
  logic              chan_q;
  logic [SW-1:0]     syn_q;
  logic [DW-1:0]     dest_q;
  logic [NPATH-1:0]  en_wr, pulse_vec;
  logic [STAT_W-1:0] en_q [NPATH];

  assign sel = reg_sel_e'(reg_addr);

  always_comb begin
    set_bits            = '0;
    set_bits[BIT_CE]    = ce_evt;
    set_bits[BIT_UE]    = ue_evt;
    set_bits[BIT_RFSH]  = rfsh_evt;
    set_bits[BIT_LOCK]  = lock_evt;
    set_bits[BIT_THERM] = therm_evt;
    clr_bits = (reg_wr && sel == RA_STAT) ? reg_wdata : '0;
  end

  ecc_status_reg #(.W(STAT_W), .MASK(STAT_MASK)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_bits (set_bits),
    .clr_bits (clr_bits),
    .stat_q   (stat_q),
    .rise     (rise)
  );

  ecc_capture #(.LW(LW), .SW(SW), .DW(DW)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_evt    (ce_evt),
    .ue_evt    (ue_evt),
    .logged_ce (stat_q[BIT_CE]),
    .logged_ue (stat_q[BIT_UE]),
    .line_in   (err_line),
    .chan_in   (err_chan),
    .syn_in    (err_syn),
    .dest_in   (err_dest),
    .line_q    (line_q),
    .chan_q    (chan_q),
    .syn_q     (syn_q),
    .dest_q    (dest_q)
  );

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    localparam logic [STAT_W-1:0] PMASK = (p == 0) ? STAT_MASK : NARROW_MASK;
    assign en_wr[p] = reg_wr && (reg_addr == RA_W'(int'(RA_EN_SERR) + p));
    ecc_report_path #(.W(STAT_W), .MASK(PMASK)) u_path (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_wr   (en_wr[p]),
      .wdata   (reg_wdata),
      .rise    (rise),
      .en_q    (en_q[p]),
      .pulse_q (pulse_vec[p])
    );
  end

  assign serr_pulse = pulse_vec[0];
  assign smi_pulse  = pulse_vec[1];
  assign sci_pulse  = pulse_vec[2];

  always_comb begin
    reg_rdata = '0;
    case (sel)
      RA_STAT:    reg_rdata[STAT_W-1:0] = stat_q;
      RA_ADDR:    reg_rdata = {line_q[LW-2:0], {RSVD_W{1'b0}}, chan_q};
      RA_EXT:     reg_rdata[0] = line_q[LW-1];
      RA_SYND:    reg_rdata[SW+DW-1:0] = {dest_q, syn_q};
      RA_EN_SERR: reg_rdata[STAT_W-1:0] = en_q[0];
      RA_EN_SMI:  reg_rdata[STAT_W-1:0] = en_q[1];
      RA_EN_SCI:  reg_rdata[STAT_W-1:0] = en_q[2];
      default:    reg_rdata = '0;
    endcase
  end

  // R10: the paths are driven by separate enables; with none set, no pulse
  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_q[0] | en_q[1] | en_q[2]) == '0) |=> (pulse_vec == '0));

  // R12: a write to a capture register alone leaves the capture intact
  p_ro_capture_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (sel == RA_ADDR) && !ce_evt && !ue_evt) |=> ($stable(line_q) && $stable(chan_q)));
endmodule

// File: tb/ecc_err_logger_test.sv
`timescale 1ns/1ps
module ecc_err_logger_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ce_evt, ue_evt, rfsh_evt, lock_evt, therm_evt;
  logic [25:0] err_line;
  logic        err_chan;
  logic [7:0]  err_syn, err_dest;
  logic [2:0]  reg_addr;
  logic        reg_wr;
  logic [15:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        serr_pulse, smi_pulse, sci_pulse;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  ecc_err_logger uut (
    .clk(clk), .rst_n(rst_n), .ce_evt(ce_evt), .ue_evt(ue_evt),
    .rfsh_evt(rfsh_evt), .lock_evt(lock_evt), .therm_evt(therm_evt),
    .err_line(err_line), .err_chan(err_chan), .err_syn(err_syn),
    .err_dest(err_dest), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .serr_pulse(serr_pulse),
    .smi_pulse(smi_pulse), .sci_pulse(sci_pulse)
  );

  // {clr, ce, ue, chan, line[25:0], syn, dest, exp_stat[1:0], exp_from[2:0]}
  localparam logic [50:0] VEC [8] = '{
    {1'b1, 1'b1, 1'b0, 1'b0, 26'h0ABCDEF, 8'h11, 8'h00, 2'b01, 3'd0},
    {1'b0, 1'b1, 1'b0, 1'b1, 26'h1111111, 8'h44, 8'h05, 2'b01, 3'd0},
    {1'b0, 1'b0, 1'b1, 1'b1, 26'h0123456, 8'h22, 8'h00, 2'b11, 3'd2},
    {1'b0, 1'b1, 1'b0, 1'b0, 26'h0555555, 8'h55, 8'h01, 2'b11, 3'd2},
    {1'b0, 1'b0, 1'b1, 1'b0, 26'h0666666, 8'h66, 8'h02, 2'b11, 3'd2},
    {1'b1, 1'b1, 1'b1, 1'b0, 26'h0777777, 8'h33, 8'h07, 2'b11, 3'd5},
    {1'b1, 1'b0, 1'b1, 1'b1, 26'h2345678, 8'h77, 8'h00, 2'b10, 3'd6},
    {1'b1, 1'b0, 1'b0, 1'b0, 26'h0000000, 8'h00, 8'h00, 2'b00, 3'd6}
  };

  function automatic string vec_tag(int i);
    case (i)
      0: return "R6 first capture";
      1: return "R8 ce frozen by ce";
      2: return "R7 ue over ce";
      3: return "R8 ce frozen by ue";
      4: return "R8 ue frozen by ue";
      5: return "R9 simultaneous";
      6: return "R4 bit32 ext";
      default: return "R3 clear keeps data";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic strobe(input logic ce, ue, rf, lk, th);
    ce_evt = ce; ue_evt = ue; rfsh_evt = rf; lock_evt = lk; therm_evt = th;
    tick();
    ce_evt = 0; ue_evt = 0; rfsh_evt = 0; lock_evt = 0; therm_evt = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [50:0] v, f;
    rst_n = 0; ce_evt = 0; ue_evt = 0; rfsh_evt = 0; lock_evt = 0; therm_evt = 0;
    err_line = '0; err_chan = 0; err_syn = '0; err_dest = '0;
    reg_addr = '0; reg_wr = 0; reg_wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();

    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      check("R1 reset register", d, 32'h0);
    end
    check("R1 reset pulses", {29'b0, serr_pulse, smi_pulse, sci_pulse}, 32'h0);

    // table of capture scenarios
    for (int i = 0; i < 8; i++) begin
      v = VEC[i];
      if (v[50]) wr(3'd0, 16'h0003);
      if (v[49] || v[48]) begin
        err_chan = v[47]; err_line = v[46:21]; err_syn = v[20:13]; err_dest = v[12:5];
        strobe(v[49], v[48], 1'b0, 1'b0, 1'b0);
      end
      f = VEC[v[2:0]];
      rd(3'd0, d); check({vec_tag(i), " status R2"}, d, {30'b0, v[4:3]});
      rd(3'd1, d); check({vec_tag(i), " addr R4"}, d, {f[45:21], 6'b0, f[47]});
      rd(3'd2, d); check({vec_tag(i), " ext R4"}, d, {31'b0, f[46]});
      rd(3'd3, d); check({vec_tag(i), " synd R5"}, d, {16'b0, f[12:5], f[20:13]});
    end

    // R3: write 0 leaves bit, clear racing an event keeps it
    strobe(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    wr(3'd0, 16'h0002);
    rd(3'd0, d); check("R3 write zero keeps bit", d, 32'h1);
    reg_addr = 3'd0; reg_wdata = 16'h0001; reg_wr = 1'b1; ce_evt = 1'b1;
    tick();
    reg_wr = 1'b0; ce_evt = 1'b0;
    rd(3'd0, d); check("R3 event beats clear", d, 32'h1);
    wr(3'd0, 16'h0001);
    rd(3'd0, d); check("R3 clear by one", d, 32'h0);

    // R2: other event bits, reserved bits
    strobe(1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    tick();
    rd(3'd0, d); check("R2 other bits sticky", d, 32'h0B00);
    wr(3'd0, 16'hFFFF);
    rd(3'd0, d); check("R2 clear all", d, 32'h0);

    // R11: enable masks
    wr(3'd4, 16'hFFFF); rd(3'd4, d); check("R11 serr enable mask", d, 32'h0B03);
    wr(3'd5, 16'hFFFF); rd(3'd5, d); check("R11 smi enable mask", d, 32'h0003);
    wr(3'd6, 16'hFFFF); rd(3'd6, d); check("R11 sci enable mask", d, 32'h0003);
    wr(3'd5, 16'h0); wr(3'd6, 16'h0); wr(3'd4, 16'h0100);

    // R10: pulses
    strobe(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R10 serr pulse", {29'b0, serr_pulse, smi_pulse, sci_pulse}, 32'h4);
    tick();
    check("R10 serr single cycle", {29'b0, serr_pulse, smi_pulse, sci_pulse}, 32'h0);
    strobe(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R10 no pulse when already set", {29'b0, serr_pulse, smi_pulse, sci_pulse}, 32'h0);
    wr(3'd4, 16'h0); wr(3'd6, 16'h0002);
    strobe(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R10 sci pulse on ue", {29'b0, serr_pulse, smi_pulse, sci_pulse}, 32'h1);
    tick();
    check("R10 sci single cycle", {29'b0, serr_pulse, smi_pulse, sci_pulse}, 32'h0);
    wr(3'd6, 16'h0); wr(3'd5, 16'h0001);
    strobe(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R10 smi pulse on ce", {29'b0, serr_pulse, smi_pulse, sci_pulse}, 32'h2);

    // R12: capture registers read-only, index 7 zero
    rd(3'd1, d);
    begin
      logic [31:0] before1, before3;
      before1 = d;
      rd(3'd3, before3);
      wr(3'd1, 16'hBEEF); wr(3'd2, 16'hFFFF); wr(3'd3, 16'hA5A5);
      rd(3'd1, d); check("R12 addr read-only", d, before1);
      rd(3'd3, d); check("R12 synd read-only", d, before3);
    end
    rd(3'd7, d); check("R12 unmapped index", d, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule